// File: doc/BRIEF.md
# Configuration Select and Output Clock Divider

This block sits between the configuration store of a clock synthesizer and its output pin. It keeps four configuration words in registers. Each word holds a feedback multiplier, a reference divider, an output divide ratio, spread-spectrum settings and a drive-strength bit. A 2-bit select input picks the word in use. The block divides the fast VCO-rate clock by the selected ratio, which may be any integer from 2 to 20. Odd ratios use the falling edge as well, so the output is high for exactly half of each period.

The multiplier, reference divider, spread and drive fields of the word in use go out on registered ports to the loop and the pad logic. A change of select is applied only when the current output period ends, so no shortened pulse reaches the pin. A low on the power-enable input stops the divider and lets go of the output. When power-enable returns, the output is driven low for one VCO cycle and then restarts from the beginning of a period.

The words reset to built-in defaults. A simple write port can overwrite any slot. The select pins pass through a synchronizer that presets to all ones, matching pins that pull high when left open.

Top module: `pll_cfg_divsel`

## Requirements
- R1: A word is laid out as mult_m1 [10:0], ref_m1 [20:11], out_div [25:21], spread_en [26], spread_center [27], spread_depth [31:28], spread_fast [32], drive_hi [33]. The multiplier and reference divider fields hold value minus one. After reset the slots hold divide 2, 3, 20 and 5 for slots 0 to 3. Slot 0 has mult_m1 99, ref_m1 4, drive_hi 1 and spread off. In slot 3 every field other than out_div is zero. The word in use drives fb_mult_m1, ref_div_m1, spread_en, spread_center, spread_depth, spread_fast and drive_hi.
- R2: When cfg_we is high at a rising clock edge, cfg_wdata is written into slot cfg_waddr. A write to a slot that is not selected does not change the output clock.
- R3: For a divide ratio N in use, the output period is N VCO cycles. The output is high for exactly N half-cycles, for both odd and even N.
- R4: An out_div value below 2 divides by 2, and a value above 20 divides by 20.
- R5: A change of the word in use, whether by select or by a write to the selected slot, takes effect only at the end of an output period. Every high and low phase therefore has the full length of either the old ratio or the new one.
- R6: While pwr_on is low, clk_oe is low from the next rising edge on, and clk_out is high impedance.
- R7: After pwr_on rises, clk_oe goes high at the next edge with clk_out low. One cycle later clk_out goes high and a new period starts.
- R8: While the divider is held (power-down or reset), the field outputs follow the synchronized select on every cycle.
- R9: During reset, clk_oe is low and the select synchronizer presets to 3, so the field outputs present slot 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on | input | 1 | High to run; low powers the output down |
| sel | input | 2 | Configuration select |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | 2 | Slot to write |
| cfg_wdata | input | 34 | Word to write |
| clk_out | output | 1 | Divided clock, high impedance when disabled |
| clk_oe | output | 1 | Output enable of clk_out |
| fb_mult_m1 | output | 11 | Feedback multiplier minus one |
| ref_div_m1 | output | 10 | Reference divider minus one |
| spread_en | output | 1 | Spread modulation on |
| spread_center | output | 1 | 1 centre spread, 0 down spread |
| spread_depth | output | 4 | Spread depth code |
| spread_fast | output | 1 | Fast modulation rate selected |
| drive_hi | output | 1 | High output drive strength |

## Verification
The divider is run at ratios 2, 3, 5, 7, 9 and 20. Using both odd and even ratios shows whether the falling-edge extension keeps the high phase at exactly N half-cycles, or whether an odd ratio is off by half a cycle. Out-of-range values 0 and 31 show that clamping works at both ends. The select is switched in the middle of a long high phase, which shows whether a change waits for the period end (all phase lengths 20 or 2) or cuts the phase short. Power-down, entered and left on a running clock, shows the one-cycle low lead-in and the field tracking while the divider is held.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int MULT_W  = 11;
  localparam int REF_W   = 10;
  localparam int DIV_W   = 5;
  localparam int DEPTH_W = 4;
  localparam logic [DIV_W-1:0] DIV_LO = DIV_W'(2);
  localparam logic [DIV_W-1:0] DIV_HI = DIV_W'(20);

  typedef struct packed {
    logic               drive_hi;
    logic               spread_fast;
    logic [DEPTH_W-1:0] spread_depth;
    logic               spread_center;
    logic               spread_en;
    logic [DIV_W-1:0]   out_div;
    logic [REF_W-1:0]   ref_m1;
    logic [MULT_W-1:0]  mult_m1;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // Built-in slot contents loaded at reset
  function automatic cfg_t default_cfg(input int idx);
    cfg_t c;
    c = '0;
    case (idx % 4)
      0: begin
        c.mult_m1  = MULT_W'(99);
        c.ref_m1   = REF_W'(4);
        c.out_div  = DIV_W'(2);
        c.drive_hi = 1'b1;
      end
      1: begin
        c.mult_m1       = MULT_W'(63);
        c.ref_m1        = REF_W'(1);
        c.out_div       = DIV_W'(3);
        c.spread_en     = 1'b1;
        c.spread_center = 1'b1;
        c.spread_depth  = DEPTH_W'(3);
        c.drive_hi      = 1'b1;
      end
      2: begin
        c.mult_m1      = '1;
        c.ref_m1       = '1;
        c.out_div      = DIV_W'(20);
        c.spread_en    = 1'b1;
        c.spread_depth = '1;
        c.spread_fast  = 1'b1;
      end
      default: c.out_div = DIV_W'(5);
    endcase
    return c;
  endfunction

  function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] v);
    if (v < DIV_LO) return DIV_LO;
    if (v > DIV_HI) return DIV_HI;
    return v;
  endfunction
endpackage

// File: rtl/pll_sel_sync.sv
module pll_sel_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) stg_q <= '1;
        else     stg_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stg_q <= '1;
        else     stg_q <= {stg_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank
  import pll_cfg_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] waddr,
  input  cfg_t             wdata,
  input  logic [SEL_W-1:0] raddr,
  output cfg_t             rdata
);
  localparam int NUM = 1 << SEL_W;

  cfg_t slot_w [NUM];

  generate
    for (genvar i = 0; i < NUM; i++) begin : g_slot
      cfg_t slot_q;
      always_ff @(posedge clk) begin
        if (rst)                                  slot_q <= default_cfg(i);
        else if (we && (waddr == SEL_W'(i)))      slot_q <= wdata;
      end
      assign slot_w[i] = slot_q;
    end
  endgenerate

  assign rdata = slot_w[raddr];
endmodule

// File: rtl/pll_out_div.sv
module pll_out_div #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             hold,
  input  logic [DIV_W-1:0] n_next,
  output logic             commit,
  output logic             clk_div
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] n_q;
  logic             pos_q;
  logic             neg_q;
  logic             wrap;

  assign wrap   = (cnt_q == n_q - ONE);
  assign commit = hold | wrap;

  // High for floor(N/2) rising-edge cycles from count zero
  always_ff @(posedge clk) begin
    if (hold) begin
      n_q   <= n_next;
      cnt_q <= n_next - ONE;
      pos_q <= 1'b0;
    end else if (wrap) begin
      n_q   <= n_next;
      cnt_q <= '0;
      pos_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + ONE;
      pos_q <= ((cnt_q + ONE) < (n_q >> 1));
    end
  end

  // Odd ratios stretch the high phase by half a cycle
  always_ff @(negedge clk) begin
    neg_q <= pos_q & n_q[0];
  end

  assign clk_div = pos_q | neg_q;
endmodule

// File: rtl/pll_cfg_divsel.sv
module pll_cfg_divsel
  import pll_cfg_pkg::*;
#(
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_on,
  input  logic [SEL_W-1:0]   sel,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_waddr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic               clk_out,
  output logic               clk_oe,
  output logic [MULT_W-1:0]  fb_mult_m1,
  output logic [REF_W-1:0]   ref_div_m1,
  output logic               spread_en,
  output logic               spread_center,
  output logic [DEPTH_W-1:0] spread_depth,
  output logic               spread_fast,
  output logic               drive_hi
);
  logic [SEL_W-1:0] sel_s;
  cfg_t             rd;
  logic             oe_q;
  logic             hold;
  logic             commit;
  logic             div_clk;

  pll_sel_sync #(.W(SEL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sel),
    .q   (sel_s)
  );

  pll_cfg_bank #(.SEL_W(SEL_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .waddr (cfg_waddr),
    .wdata (cfg_t'(cfg_wdata)),
    .raddr (sel_s),
    .rdata (rd)
  );

  assign hold = rst | ~oe_q | ~pwr_on;

  pll_out_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .hold    (hold),
    .n_next  (clamp_div(rd.out_div)),
    .commit  (commit),
    .clk_div (div_clk)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= pwr_on;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      fb_mult_m1    <= rd.mult_m1;
      ref_div_m1    <= rd.ref_m1;
      spread_en     <= rd.spread_en;
      spread_center <= rd.spread_center;
      spread_depth  <= rd.spread_depth;
      spread_fast   <= rd.spread_fast;
      drive_hi      <= rd.drive_hi;
    end
  end

  assign clk_oe  = oe_q;
  assign clk_out = oe_q ? div_clk : 1'bz;
endmodule

// File: rtl/pll_cfg_divsel_chk.sv
module pll_cfg_divsel_chk (
  input logic        clk,
  input logic        rst,
  input logic        pwr_on,
  input logic        clk_oe,
  input logic        div_clk,
  input logic        commit,
  input logic [21:0] fields
);
  // R6: power-down releases the pin at the next edge
  assert_oe_off_R6: assert property (@(posedge clk) disable iff (rst)
    !pwr_on |=> !clk_oe);

  // R7: the pin is driven low first when enabled
  assert_wake_low_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_oe) |-> !div_clk);

  // R5: fields change only on a period boundary or while held
  assert_cfg_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(fields));

  // R3: a period boundary while running starts a high phase
  assert_wrap_rises_R3: assert property (@(posedge clk) disable iff (rst)
    (commit && clk_oe && pwr_on) |=> div_clk);

  // R9: no drive while in reset
  assert_reset_off_R9: assert property (@(posedge clk)
    rst |=> !clk_oe);
endmodule

bind pll_cfg_divsel pll_cfg_divsel_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .pwr_on  (pwr_on),
  .clk_oe  (clk_oe),
  .div_clk (div_clk),
  .commit  (commit),
  .fields  ({fb_mult_m1, ref_div_m1, drive_hi})
);

// File: tb/pll_cfg_divsel_tb_top.sv
module pll_cfg_divsel_tb_top;
  import pll_cfg_pkg::*;

  logic               clk = 1'b0;
  logic               rst;
  logic               pwr_on;
  logic [1:0]         sel;
  logic               cfg_we;
  logic [1:0]         cfg_waddr;
  logic [CFG_W-1:0]   cfg_wdata;
  wire                clk_out;
  logic               clk_oe;
  logic [MULT_W-1:0]  fb_mult_m1;
  logic [REF_W-1:0]   ref_div_m1;
  logic               spread_en;
  logic               spread_center;
  logic [DEPTH_W-1:0] spread_depth;
  logic               spread_fast;
  logic               drive_hi;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pll_cfg_divsel dut_i (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .sel(sel),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .clk_out(clk_out), .clk_oe(clk_oe),
    .fb_mult_m1(fb_mult_m1), .ref_div_m1(ref_div_m1),
    .spread_en(spread_en), .spread_center(spread_center),
    .spread_depth(spread_depth), .spread_fast(spread_fast),
    .drive_hi(drive_hi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 2 ns after a rising edge
  task automatic at_pos();
    @(posedge clk);
    #2;
  endtask

  task automatic load(input logic [1:0] slot, input cfg_t w);
    at_pos();
    cfg_we = 1'b1; cfg_waddr = slot; cfg_wdata = w;
    at_pos();
    cfg_we = 1'b0;
  endtask

  // Samples clk_out once per half cycle and checks the lengths of complete phases
  task automatic measure(input int halves, input int a, input int b,
                         input int sw_at, input logic [1:0] sw_sel,
                         output int good, output int bad, output int last);
    logic prev;
    int   run;
    bit   first;
    good = 0; bad = 0; last = 0; run = 0; first = 1'b1; prev = 1'b0;
    at_pos();
    for (int h = 0; h < halves; h++) begin
      logic s;
      if (h == sw_at) sel = sw_sel;
      s = clk_out;
      if (h == 0) begin
        prev = s; run = 1;
      end else if (s == prev) begin
        run++;
      end else begin
        if (!first) begin
          if (run == a || run == b) good++;
          else begin
            bad++;
            $display("  phase length %0d half-cycles seen", run);
          end
          last = run;
        end
        first = 1'b0; run = 1; prev = s;
      end
      #5;
    end
  endtask

  task automatic expect_ratio(input int n, input string req);
    int g, bd, l;
    measure(8 * n + 8, n, n, -1, 2'd0, g, bd, l);
    check(bd == 0 && g >= 2, req, bd, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; pwr_on = 1'b1; sel = 2'd0; cfg_we = 1'b0;
    cfg_waddr = '0; cfg_wdata = '0;
    repeat (4) at_pos();
    check(clk_oe == 1'b0, "R9 oe in reset", int'(clk_oe), 0);
    check(fb_mult_m1 == 0 && ref_div_m1 == 0, "R9 slot3 fields", int'(fb_mult_m1), 0);
    check(drive_hi == 1'b0, "R9 slot3 drive", int'(drive_hi), 0);
    rst = 1'b0;
    repeat (10) at_pos();
    check(clk_oe == 1'b1, "R7 oe after reset", int'(clk_oe), 1);
  endtask

  task automatic t_defaults();
    sel = 2'd0; repeat (50) at_pos();
    expect_ratio(2, "R3 divide 2");
    check(fb_mult_m1 == 99 && ref_div_m1 == 4 && drive_hi == 1'b1,
          "R1 slot0 fields", int'(fb_mult_m1), 99);
    sel = 2'd1; repeat (50) at_pos();
    expect_ratio(3, "R3 divide 3 odd");
    sel = 2'd3; repeat (50) at_pos();
    expect_ratio(5, "R3 divide 5 odd");
    sel = 2'd2; repeat (60) at_pos();
    expect_ratio(20, "R3 divide 20");
  endtask

  task automatic t_switch();
    int g, bd, l;
    sel = 2'd2; repeat (60) at_pos();
    measure(220, 20, 2, 50, 2'd0, g, bd, l);
    check(bd == 0 && g >= 3, "R5 no runt on select change", bd, 0);
    check(l == 2, "R5 new ratio after boundary", l, 2);
  endtask

  task automatic t_power();
    sel = 2'd3; repeat (50) at_pos();
    pwr_on = 1'b0;
    at_pos();
    check(clk_oe == 1'b0, "R6 oe off next edge", int'(clk_oe), 0);
    sel = 2'd0;
    repeat (6) at_pos();
    check(clk_oe == 1'b0, "R6 oe stays off", int'(clk_oe), 0);
    check(fb_mult_m1 == 99 && ref_div_m1 == 4, "R8 fields follow sel in hold",
          int'(fb_mult_m1), 99);
    pwr_on = 1'b1;
    at_pos();
    check(clk_oe == 1'b1 && clk_out == 1'b0, "R7 driven low first",
          int'(clk_out), 0);
    at_pos();
    check(clk_out == 1'b1, "R7 first high", int'(clk_out), 1);
    expect_ratio(2, "R3 after wake");
  endtask

  task automatic t_load();
    cfg_t w;
    int   g, bd, l;
    w = '0;
    w.mult_m1 = MULT_W'(1234); w.ref_m1 = REF_W'(567); w.out_div = DIV_W'(7);
    w.spread_en = 1'b1; w.spread_center = 1'b0; w.spread_depth = DEPTH_W'(9);
    w.spread_fast = 1'b1; w.drive_hi = 1'b1;
    sel = 2'd0; repeat (20) at_pos();
    load(2'd1, w);
    measure(40, 2, 2, -1, 2'd0, g, bd, l);
    check(bd == 0 && g >= 2, "R2 inactive write ignored", bd, 0);
    sel = 2'd1; repeat (50) at_pos();
    check(fb_mult_m1 == 1234, "R1 mult field", int'(fb_mult_m1), 1234);
    check(ref_div_m1 == 567, "R1 ref field", int'(ref_div_m1), 567);
    check(spread_en && !spread_center && spread_fast && drive_hi,
          "R1 flag fields", int'({spread_en, spread_center, spread_fast, drive_hi}), 11);
    check(spread_depth == 9, "R2 depth field", int'(spread_depth), 9);
    expect_ratio(7, "R3 divide 7 loaded");
    w.out_div = DIV_W'(9);
    load(2'd1, w);
    repeat (30) at_pos();
    expect_ratio(9, "R2 rewrite selected slot");
  endtask

  task automatic t_clamp();
    cfg_t w;
    w = default_cfg(0);
    sel = 2'd1;
    w.out_div = DIV_W'(0);
    load(2'd1, w);
    repeat (50) at_pos();
    expect_ratio(2, "R4 clamp low");
    w.out_div = DIV_W'(31);
    load(2'd1, w);
    repeat (50) at_pos();
    expect_ratio(20, "R4 clamp high");
  endtask

  initial begin
    t_reset();
    t_defaults();
    t_switch();
    t_power();
    t_load();
    t_clamp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule